// File: doc/BRIEF.md
# Dual-Band Synthesizer Loop Divider

This block is the feedback divider of a frequency synthesizer. Two input clocks that have already been turned into one-cycle event strobes in the system clock domain, a high-band source and a low-band source, are counted down by a ratio taken from a 16-bit divisor word and two mode bits. One output pulse goes to the phase comparator for each full division period. A second counter divides a 75 kHz crystal event strobe by a ratio picked by a 4-bit reference code. Its output is the reference tick that the comparator sees.

The mode bits choose the source and how the divisor word is read. With the band bit set, the high-band source is counted and the set value is doubled. This accounts for a halving stage that sits ahead of the block. With the band bit clear and the range bit set, the low-band source is divided by the full 16-bit value. With both bits clear, only the upper twelve bits of the word are used. Two reference codes put the loop into an inhibit state, and one of them also requests that the crystal be stopped.

Top module: `loopdiv_top`

## Requirements
- R1: With bandSel=1, fbPulse fires once per 2×divWord events on hiBandEvt, and loBandEvt has no effect.
- R2: With bandSel=0 and rangeSel=1, fbPulse fires once per divWord events on loBandEvt, and hiBandEvt has no effect.
- R3: With bandSel=0 and rangeSel=0, the divisor is divWord[15:4], counted on loBandEvt, and divWord[3:0] has no effect.
- R4: A set value below the mode's minimum is raised to that minimum. The minimum is 272 for the two 16-bit modes and 4 for the 12-bit mode.
- R5: refPulse fires once per K events on xtalEvt. K is 3 for refCode 0..3, 6 for 4, 12 for 5, 24 for 6 and 7, 15 for 8 and 9, 30 for 10, 75 for 11, 25 for 12, and 5 for 13.
- R6: refCode 15 or 14 raises loopInhibit, suppresses both pulses and clears both counters. When the inhibit is released, each output needs a full period again.
- R7: xtalStop is 1 only for refCode 14.
- R8: A change of divisor, mode or reference code made part-way through a period takes effect from the next period. The current period completes with the old ratio.
- R9: After reset, fbPulse and refPulse are 0, and the first period has full length.
- R10: Each pulse is high for exactly one clock cycle. It is high in the cycle after the clock edge that samples the final event of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hiBandEvt | input | 1 | One-cycle event strobe of the high-band source |
| loBandEvt | input | 1 | One-cycle event strobe of the low-band source |
| xtalEvt | input | 1 | One-cycle event strobe of the 75 kHz crystal |
| divWord | input | 16 | Divisor word |
| bandSel | input | 1 | 1 selects the high band with doubled ratio |
| rangeSel | input | 1 | With bandSel=0: 1 selects the 16-bit divisor, 0 selects the 12-bit divisor |
| refCode | input | 4 | Reference ratio or inhibit code |
| fbPulse | output | 1 | Divided feedback pulse |
| refPulse | output | 1 | Reference tick |
| loopInhibit | output | 1 | Loop inhibited; the comparator output is to float |
| xtalStop | output | 1 | Crystal stop request |

## Verification
A pulse is registered, so it is visible in the cycle after the rising edge that samples the last event of a period. loopInhibit and xtalStop follow refCode within the same cycle. The bench changes inputs at a falling edge and holds each event strobe for one cycle. It reads the pulse outputs at the following falling edge, which is the one cycle in which a pulse caused by that event can be high. Boundary runs stop exactly one event short of a period and then add that one event. This pins each ratio to an exact count rather than a range.

// File: rtl/loopdiv_pkg.sv
`timescale 1ns/1ps
package loopdiv_pkg;
  localparam int WORD_W = 16;
  localparam int FB_W   = WORD_W + 1;
  localparam int REF_W  = 7;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic              fbStep;
    logic              refStep;
    logic              hold;
    logic [FB_W-1:0]   fbRatio;
    logic [REF_W-1:0]  refRatio;
  } dpCtrl_t;
endpackage

// File: rtl/loopdiv_ctrl.sv
`timescale 1ns/1ps
module loopdiv_ctrl
  import loopdiv_pkg::*;
#(
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4
) (
  input  logic              hiBandEvt,
  input  logic              loBandEvt,
  input  logic              xtalEvt,
  input  logic [WORD_W-1:0] divWord,
  input  logic              bandSel,
  input  logic              rangeSel,
  input  logic [CODE_W-1:0] refCode,
  output dpCtrl_t           ctl,
  output logic              loopInhibit,
  output logic              xtalStop
);
  localparam int NARROW_W = WORD_W - 4;

  logic                narrowMode;
  logic [NARROW_W-1:0] narrowVal;
  logic [WORD_W-1:0]   setVal;

  function automatic logic [REF_W-1:0] refRatioOf(input logic [CODE_W-1:0] code);
    case (code)
      4'd4:          refRatioOf = REF_W'(6);
      4'd5:          refRatioOf = REF_W'(12);
      4'd6, 4'd7:    refRatioOf = REF_W'(24);
      4'd8, 4'd9:    refRatioOf = REF_W'(15);
      4'd10:         refRatioOf = REF_W'(30);
      4'd11:         refRatioOf = REF_W'(75);
      4'd12:         refRatioOf = REF_W'(25);
      4'd13:         refRatioOf = REF_W'(5);
      default:       refRatioOf = REF_W'(3);
    endcase
  endfunction

  always_comb begin
    narrowMode = !bandSel && !rangeSel;
    narrowVal  = divWord[WORD_W-1:4];
    if (narrowMode)
      setVal = (narrowVal < NARROW_W'(NARROW_MIN)) ? WORD_W'(NARROW_MIN)
                                                   : WORD_W'(narrowVal);
    else
      setVal = (divWord < WORD_W'(WIDE_MIN)) ? WORD_W'(WIDE_MIN) : divWord;

    ctl.fbRatio  = bandSel ? {setVal, 1'b0} : {1'b0, setVal};
    ctl.fbStep   = bandSel ? hiBandEvt : loBandEvt;
    ctl.refStep  = xtalEvt;
    ctl.refRatio = refRatioOf(refCode);
    ctl.hold     = (refCode[3:1] == 3'b111);
    loopInhibit  = ctl.hold;
    xtalStop     = (refCode == 4'b1110);
  end
endmodule

// File: rtl/loopdiv_period_counter.sv
`timescale 1ns/1ps
module loopdiv_period_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hold,
  input  logic         step,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] count;
  logic [W-1:0] heldRatio;
  logic [W-1:0] effRatio;

  // The live ratio is only sampled while a period has not started yet.
  always_comb effRatio = (count == '0) ? ratio : heldRatio;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      heldRatio <= '0;
      tick      <= 1'b0;
    end else if (hold) begin
      count <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (step) begin
        if (count == '0) heldRatio <= ratio;
        if (count == effRatio - W'(1)) begin
          count <= '0;
          tick  <= 1'b1;
        end else begin
          count <= count + W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/loopdiv_datapath.sv
`timescale 1ns/1ps
module loopdiv_datapath
  import loopdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctl,
  output logic    fbPulse,
  output logic    refPulse
);
  loopdiv_period_counter #(.W(FB_W)) i_fbCounter (
    .clk   (clk),
    .rstN  (rstN),
    .hold  (ctl.hold),
    .step  (ctl.fbStep),
    .ratio (ctl.fbRatio),
    .tick  (fbPulse)
  );

  loopdiv_period_counter #(.W(REF_W)) i_refCounter (
    .clk   (clk),
    .rstN  (rstN),
    .hold  (ctl.hold),
    .step  (ctl.refStep),
    .ratio (ctl.refRatio),
    .tick  (refPulse)
  );
endmodule

// File: rtl/loopdiv_top.sv
`timescale 1ns/1ps
module loopdiv_top
  import loopdiv_pkg::*;
#(
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hiBandEvt,
  input  logic              loBandEvt,
  input  logic              xtalEvt,
  input  logic [WORD_W-1:0] divWord,
  input  logic              bandSel,
  input  logic              rangeSel,
  input  logic [CODE_W-1:0] refCode,
  output logic              fbPulse,
  output logic              refPulse,
  output logic              loopInhibit,
  output logic              xtalStop
);
  dpCtrl_t ctl;

  loopdiv_ctrl #(.WIDE_MIN(WIDE_MIN), .NARROW_MIN(NARROW_MIN)) i_ctrl (
    .hiBandEvt   (hiBandEvt),
    .loBandEvt   (loBandEvt),
    .xtalEvt     (xtalEvt),
    .divWord     (divWord),
    .bandSel     (bandSel),
    .rangeSel    (rangeSel),
    .refCode     (refCode),
    .ctl         (ctl),
    .loopInhibit (loopInhibit),
    .xtalStop    (xtalStop)
  );

  loopdiv_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .fbPulse  (fbPulse),
    .refPulse (refPulse)
  );
endmodule

// File: rtl/loopdiv_checker.sv
`timescale 1ns/1ps
module loopdiv_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hiBandEvt,
  input logic       loBandEvt,
  input logic       xtalEvt,
  input logic       bandSel,
  input logic [3:0] refCode,
  input logic       fbPulse,
  input logic       refPulse,
  input logic       loopInhibit,
  input logic       xtalStop
);
  AST_FB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse); // R10
  AST_REF_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |=> !refPulse); // R10
  AST_FB_FROM_SELECTED_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |-> $past(bandSel ? hiBandEvt : loBandEvt)); // R1
  AST_REF_FROM_XTAL: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |-> $past(xtalEvt)); // R5
  AST_INHIBIT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    loopInhibit |=> (!fbPulse && !refPulse)); // R6
  AST_XTAL_STOP_CODE: assert property (@(posedge clk) disable iff (!rstN)
    xtalStop |-> (loopInhibit && refCode == 4'b1110)); // R7
endmodule

bind loopdiv_top loopdiv_checker i_loopdivChecker (
  .clk         (clk),
  .rstN        (rstN),
  .hiBandEvt   (hiBandEvt),
  .loBandEvt   (loBandEvt),
  .xtalEvt     (xtalEvt),
  .bandSel     (bandSel),
  .refCode     (refCode),
  .fbPulse     (fbPulse),
  .refPulse    (refPulse),
  .loopInhibit (loopInhibit),
  .xtalStop    (xtalStop)
);

// File: tb/test_loopdiv_top.sv
`timescale 1ns/1ps
module test_loopdiv_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hiBandEvt = 1'b0;
  logic        loBandEvt = 1'b0;
  logic        xtalEvt = 1'b0;
  logic [15:0] divWord = 16'd0;
  logic        bandSel = 1'b0;
  logic        rangeSel = 1'b0;
  logic [3:0]  refCode = 4'd0;
  logic        fbPulse, refPulse, loopInhibit, xtalStop;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  loopdiv_top i_loopdiv_top (
    .clk(clk), .rstN(rstN), .hiBandEvt(hiBandEvt), .loBandEvt(loBandEvt),
    .xtalEvt(xtalEvt), .divWord(divWord), .bandSel(bandSel), .rangeSel(rangeSel),
    .refCode(refCode), .fbPulse(fbPulse), .refPulse(refPulse),
    .loopInhibit(loopInhibit), .xtalStop(xtalStop)
  );

  typedef struct packed {
    logic        band;
    logic        range;
    logic [15:0] word;
    logic        noise;
    int          nEv;
    int          expPulses;
  } vec_t;

  // band, range, word, drive the unselected source too, events, expected pulses
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 16'd2014, 1'b1, 4028, 1},  // R1 high band, 2x ratio
    '{1'b1, 1'b0, 16'd2014, 1'b0, 4027, 0},  // R1 one short
    '{1'b0, 1'b1, 16'd300,  1'b1, 900,  3},  // R2 low band direct
    '{1'b0, 1'b1, 16'd300,  1'b0, 899,  2},  // R2 one short
    '{1'b0, 1'b0, 16'h1E6F, 1'b1, 486,  1},  // R3 12-bit, low nibble ignored
    '{1'b0, 1'b0, 16'h1E60, 1'b0, 485,  0},  // R3 one short
    '{1'b0, 1'b1, 16'd10,   1'b0, 544,  2},  // R4 wide clamp to 272
    '{1'b1, 1'b0, 16'd100,  1'b0, 1088, 2},  // R4 high band clamp, 2x272
    '{1'b0, 1'b0, 16'h0015, 1'b1, 12,   3},  // R4 narrow clamp to 4
    '{1'b0, 1'b0, 16'h0030, 1'b0, 7,    1}   // R4 narrow clamp, one short of 2
  };

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Each event strobe lasts one cycle, followed by one idle cycle.
  task automatic sendEvents(input int n, input bit hi, input bit lo, input bit xt,
                            output int fbSeen, output int refSeen);
    fbSeen = 0;
    refSeen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hiBandEvt = hi; loBandEvt = lo; xtalEvt = xt;
      @(negedge clk);
      hiBandEvt = 1'b0; loBandEvt = 1'b0; xtalEvt = 1'b0;
      if (fbPulse) fbSeen++;
      if (refPulse) refSeen++;
    end
  endtask

  function automatic int expRefRatio(input int code);
    case (code)
      0, 1, 2, 3: return 3;
      4:          return 6;
      5:          return 12;
      6, 7:       return 24;
      8, 9:       return 15;
      10:         return 30;
      11:         return 75;
      12:         return 25;
      default:    return 5;
    endcase
  endfunction

  initial begin
    int fb, rf;
    // R9 reset state
    doReset();
    check("R9 fbPulse after reset", fbPulse, 0);
    check("R9 refPulse after reset", refPulse, 0);
    check("R7 xtalStop code0", xtalStop, 0);
    check("R6 loopInhibit code0", loopInhibit, 0);

    // Vector table: R1..R4
    for (int v = 0; v < 10; v++) begin
      bandSel = VECS[v].band;
      rangeSel = VECS[v].range;
      divWord = VECS[v].word;
      refCode = 4'd0;
      doReset();
      if (VECS[v].band)
        sendEvents(VECS[v].nEv, 1'b1, VECS[v].noise, 1'b0, fb, rf);
      else
        sendEvents(VECS[v].nEv, VECS[v].noise, 1'b1, 1'b0, fb, rf);
      check($sformatf("R1/R2/R3/R4 vector %0d pulses", v), fb, VECS[v].expPulses);
    end

    // R5 reference ratios, each pinned exactly
    for (int c = 0; c < 14; c++) begin
      refCode = 4'(c);
      doReset();
      sendEvents(expRefRatio(c) - 1, 1'b0, 1'b0, 1'b1, fb, rf);
      check($sformatf("R5 code %0d before period end", c), rf, 0);
      sendEvents(1, 1'b0, 1'b0, 1'b1, fb, rf);
      check($sformatf("R5 code %0d at period end", c), rf, 1);
    end

    // R6 / R7 inhibit codes
    for (int c = 14; c < 16; c++) begin
      refCode = 4'(c);
      bandSel = 1'b0; rangeSel = 1'b1; divWord = 16'd300;
      doReset();
      check($sformatf("R6 loopInhibit code %0d", c), loopInhibit, 1);
      check($sformatf("R7 xtalStop code %0d", c), xtalStop, (c == 14) ? 1 : 0);
      sendEvents(320, 1'b1, 1'b1, 1'b1, fb, rf);
      check($sformatf("R6 fb silent code %0d", c), fb, 0);
      check($sformatf("R6 ref silent code %0d", c), rf, 0);
    end

    // R6 inhibit mid-period restarts counting
    refCode = 4'd0; bandSel = 1'b0; rangeSel = 1'b1; divWord = 16'd300;
    doReset();
    sendEvents(150, 1'b0, 1'b1, 1'b0, fb, rf);
    @(negedge clk); refCode = 4'd15;
    sendEvents(10, 1'b0, 1'b1, 1'b0, fb, rf);
    check("R6 fb during inhibit", fb, 0);
    @(negedge clk); refCode = 4'd0;
    sendEvents(299, 1'b0, 1'b1, 1'b0, fb, rf);
    check("R6 full period after release, one short", fb, 0);
    sendEvents(1, 1'b0, 1'b1, 1'b0, fb, rf);
    check("R6 full period after release", fb, 1);

    // R8 divisor change mid-period
    doReset();
    sendEvents(100, 1'b0, 1'b1, 1'b0, fb, rf);
    @(negedge clk); divWord = 16'd400;
    sendEvents(199, 1'b0, 1'b1, 1'b0, fb, rf);
    check("R8 old ratio still running", fb, 0);
    sendEvents(1, 1'b0, 1'b1, 1'b0, fb, rf);
    check("R8 old period completes at 300", fb, 1);
    sendEvents(399, 1'b0, 1'b1, 1'b0, fb, rf);
    check("R8 new ratio one short", fb, 0);
    sendEvents(1, 1'b0, 1'b1, 1'b0, fb, rf);
    check("R8 new ratio 400", fb, 1);

    // R8 reference code change mid-period
    refCode = 4'd11;
    doReset();
    sendEvents(10, 1'b0, 1'b0, 1'b1, fb, rf);
    @(negedge clk); refCode = 4'd0;
    sendEvents(65, 1'b0, 1'b0, 1'b1, fb, rf);
    check("R8 ref old period of 75", rf, 1);

    // R10 pulse width: the pulse is gone one cycle later
    refCode = 4'd0;
    doReset();
    sendEvents(2, 1'b0, 1'b0, 1'b1, fb, rf);
    @(negedge clk); xtalEvt = 1'b1;
    @(negedge clk); xtalEvt = 1'b0;
    check("R10 refPulse in cycle after final event", refPulse, 1);
    @(negedge clk);
    check("R10 refPulse one cycle wide", refPulse, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule